// File: doc/BRIEF.md
# Iterative Hash Compression Round Engine

This block performs the compression step of a 256-bit iterative hash. It keeps a 256-bit chaining value and eight 32-bit working words. A block starts from the current chaining value. The engine then runs one round in every cycle in which the message expander presents a valid pair: an expanded word and its companion word, which is the expanded word XORed with the word four positions later. After the sixty-fourth round, each working word is XORed with the chaining value saved at the start of the block, and the result becomes the new chaining value.

A host first pulses the init input, which loads the fixed initial value. For each 64-byte block it then pulses start and streams 64 word pairs. The expander may stall the stream at any point. The chaining value carries over from one block to the next. The next block may start in the same cycle that the previous block finishes. Padding and length encoding are handled outside this block.

Top module: `hash_round_core`

## Requirements
- R1: After reset, and in the cycle after init_i is high, digest_o equals 7380166F 4914B2B9 172442D7 DA8A0600 A96F30BC 163138AA E38DEE4D B0FB0E4E, with the first word in bits 255:224, and busy_o is low.
- R2: When the engine is idle, a start_i pulse copies the chaining value into the working words, clears the round count and raises busy_o in the next cycle.
- R3: While busy, a round is executed only in a cycle where w_valid_i is high. In a cycle where it is low, the state, busy_o and digest_o hold.
- R4: Round j computes the following. All additions are modulo 2^32.
  - X = A<<<12 and SS1 = (X + E + K_j)<<<7, where K_j is 79CC4519 (j<16) or 7A879D8A (j>=16), rotated left by j mod 32.
  - SS2 = SS1 ^ X.
  - TT1 = F1 + D + SS2 + wp_i and TT2 = F2 + H + SS1 + w_i.
  - The new words are A=TT1, B=A, C=B<<<9, D=C, E=TT2^(TT2<<<9)^(TT2<<<17), F=E, G=F<<<19 and H=G.
- R5: For rounds 0 to 15, F1 and F2 are the three-input XOR. From round 16 on, F1 is the bitwise majority of A, B and C, and F2 is (E&F)|(~E&G).
- R6: In the cycle after round 63 executes, digest_o holds the working words XORed with the saved chaining value, done_o is high for that one cycle, and busy_o is low unless a new block was started.
- R7: Consecutive blocks chain: each block starts from the digest left by the previous one.
- R8: A start_i that coincides with the round-63 cycle begins the next block from the new chaining value, without an idle cycle.
- R9: start_i while busy before round 63 is ignored, and w_valid_i while idle is ignored. The digest and round progress are unaffected.
- R10: init_i has priority over everything else. It abandons a block in progress, loads the initial value and clears busy_o.
- R11: The padded three-byte message 616263 gives the digest 66c7f0f4 62eeedd9 d1f2d46b dc10e4e2 4167c487 5cf2f7a2 297da02b 8f4ba8e0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Load the initial chaining value and abort any block |
| start_i | input | 1 | Begin a block from the current chaining value |
| w_valid_i | input | 1 | A word pair is present this cycle |
| w_i | input | 32 | Expanded word W[j] |
| wp_i | input | 32 | Companion word W[j]^W[j+4] |
| busy_o | output | 1 | Block in progress |
| done_o | output | 1 | One-cycle pulse when a new digest is valid |
| digest_o | output | 256 | Chaining value, first word in the top bits |

## Verification
Two events can fall in the same cycle: the final round, which folds the working words into the chaining value, and a start request for the next block. The bench provokes this by asserting start_i in exactly the round-63 cycle. It then judges the result by checking two things. First, busy_o never drops. Second, the second digest equals the compression of the second block applied to the first block's digest, not to the stale chaining value. A cycle-accurate behavioural model predicts busy, done and digest on every clock, including stalled cycles and aborted blocks.

// File: rtl/hash_round_core.sv
module hash_round_core #(
  parameter int ROUNDS = 64,
  parameter int SPLIT  = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_i,
  input  logic         start_i,
  input  logic         w_valid_i,
  input  logic [31:0]  w_i,
  input  logic [31:0]  wp_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [255:0] digest_o
);
  localparam int CW = $clog2(ROUNDS);
  localparam logic [255:0] IV =
    256'h7380166F_4914B2B9_172442D7_DA8A0600_A96F30BC_163138AA_E38DEE4D_B0FB0E4E;
  localparam logic [31:0] K_LO = 32'h79CC4519;
  localparam logic [31:0] K_HI = 32'h7A879D8A;

  function automatic logic [31:0] rol(input logic [31:0] x, input int n);
    int s;
    s = n % 32;
    return (s == 0) ? x : ((x << s) | (x >> (32 - s)));
  endfunction

  logic [31:0]   a, b, c, d, e, f, g, h;
  logic [255:0]  cv;
  logic [CW-1:0] rnd;
  logic          busy;

  logic          early, fire, last, take;
  logic [31:0]   kj, x12, ss1, ss2, ff, gg, tt1, tt2, p0;
  logic [255:0]  nxt, newcv;

  assign early = int'(rnd) < SPLIT;
  assign kj    = rol(early ? K_LO : K_HI, int'(rnd));
  assign x12   = rol(a, 12);
  assign ss1   = rol(x12 + e + kj, 7);
  assign ss2   = ss1 ^ x12;
  assign ff    = early ? (a ^ b ^ c) : ((a & b) | (a & c) | (b & c));
  assign gg    = early ? (e ^ f ^ g) : ((e & f) | (~e & g));
  assign tt1   = ff + d + ss2 + wp_i;
  assign tt2   = gg + h + ss1 + w_i;
  assign p0    = tt2 ^ rol(tt2, 9) ^ rol(tt2, 17);
  assign nxt   = {tt1, a, rol(b, 9), c, p0, e, rol(f, 19), g};
  assign newcv = nxt ^ cv;

  assign fire  = busy && w_valid_i;
  assign last  = fire && (int'(rnd) == ROUNDS - 1);
  assign take  = start_i && (!busy || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv   <= IV;
      busy <= 1'b0;
      done_o <= 1'b0;
      rnd  <= '0;
      {a, b, c, d, e, f, g, h} <= '0;
    end else if (init_i) begin
      cv   <= IV;
      busy <= 1'b0;
      done_o <= 1'b0;
      rnd  <= '0;
    end else begin
      done_o <= last;
      if (last) cv <= newcv;
      if (fire) begin
        {a, b, c, d, e, f, g, h} <= nxt;
        rnd <= last ? '0 : rnd + 1'b1;
      end
      if (take) begin
        {a, b, c, d, e, f, g, h} <= last ? newcv : cv;
        rnd  <= '0;
        busy <= 1'b1;
      end else if (last) begin
        busy <= 1'b0;
      end
    end
  end

  assign busy_o   = busy;
  assign digest_o = cv;
endmodule

module hash_round_core_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         init_i,
  input logic         w_valid_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [255:0] digest_o
);
  localparam logic [255:0] IV0 =
    256'h7380166F_4914B2B9_172442D7_DA8A0600_A96F30BC_163138AA_E38DEE4D_B0FB0E4E;

  a_r1_init_loads: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (digest_o == IV0) && !busy_o);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));
  a_r9_idle_digest_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !init_i) |=> $stable(digest_o));
  a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !w_valid_i && !init_i) |=> ($stable(digest_o) && busy_o && !done_o));
  a_r10_busy_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o || $past(init_i)));
endmodule

bind hash_round_core hash_round_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .init_i(init_i), .w_valid_i(w_valid_i),
  .busy_o(busy_o), .done_o(done_o), .digest_o(digest_o)
);

// File: tb/hash_round_core_tb.sv
`timescale 1ns/1ps
module hash_round_core_tb;
  localparam logic [255:0] IV =
    256'h7380166F_4914B2B9_172442D7_DA8A0600_A96F30BC_163138AA_E38DEE4D_B0FB0E4E;
  localparam logic [255:0] KAT =
    256'h66c7f0f4_62eeedd9_d1f2d46b_dc10e4e2_4167c487_5cf2f7a2_297da02b_8f4ba8e0;

  logic clk = 0, rst_n = 0;
  logic init_i = 0, start_i = 0, w_valid_i = 0;
  logic [31:0] w_i = 0, wp_i = 0;
  logic busy_o, done_o;
  logic [255:0] digest_o;

  always #2.5 clk = ~clk;

  hash_round_core u_dut (.clk(clk), .rst_n(rst_n), .init_i(init_i), .start_i(start_i),
    .w_valid_i(w_valid_i), .w_i(w_i), .wp_i(wp_i), .busy_o(busy_o), .done_o(done_o),
    .digest_o(digest_o));

  int n_tests = 0, n_fail = 0;

  logic [31:0]  blk_abc [16];
  logic [31:0]  blk_b   [16];
  logic [31:0]  nxt_blk [16];
  logic [31:0]  m_w     [68];
  logic [255:0] m_cv, m_tgt;
  bit           m_busy, m_done;
  int           m_cnt;

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    int s;
    s = n % 32;
    return (s == 0) ? x : ((x << s) | (x >> (32 - s)));
  endfunction

  function automatic void expand(input logic [31:0] m[16], output logic [31:0] wv[68]);
    logic [31:0] t;
    for (int j = 0; j < 16; j++) wv[j] = m[j];
    for (int j = 16; j < 68; j++) begin
      t = wv[j-16] ^ wv[j-9] ^ rl(wv[j-3], 15);
      wv[j] = t ^ rl(t, 15) ^ rl(t, 23) ^ rl(wv[j-13], 7) ^ wv[j-6];
    end
  endfunction

  function automatic logic [255:0] compress(input logic [255:0] v, input logic [31:0] m[16]);
    logic [31:0] wv[68];
    logic [31:0] r[8];
    logic [31:0] s1, s2, u1, u2, k, f1, f2;
    expand(m, wv);
    for (int i = 0; i < 8; i++) r[i] = v[255-32*i -: 32];
    for (int j = 0; j < 64; j++) begin
      k  = rl((j < 16) ? 32'h79CC4519 : 32'h7A879D8A, j);
      s1 = rl(rl(r[0], 12) + r[4] + k, 7);
      s2 = s1 ^ rl(r[0], 12);
      f1 = (j < 16) ? (r[0] ^ r[1] ^ r[2]) : ((r[0] & r[1]) | (r[0] & r[2]) | (r[1] & r[2]));
      f2 = (j < 16) ? (r[4] ^ r[5] ^ r[6]) : ((r[4] & r[5]) | (~r[4] & r[6]));
      u1 = f1 + r[3] + s2 + (wv[j] ^ wv[j+4]);
      u2 = f2 + r[7] + s1 + wv[j];
      r[3] = r[2]; r[2] = rl(r[1], 9); r[1] = r[0]; r[0] = u1;
      r[7] = r[6]; r[6] = rl(r[5], 19); r[5] = r[4];
      r[4] = u2 ^ rl(u2, 9) ^ rl(u2, 17);
    end
    for (int i = 0; i < 8; i++) v[255-32*i -: 32] = v[255-32*i -: 32] ^ r[i];
    return v;
  endfunction

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit ini, input bit st, input bit vld);
    bit last;
    init_i = ini; start_i = st; w_valid_i = vld;
    if (m_busy) begin
      w_i = m_w[m_cnt]; wp_i = m_w[m_cnt] ^ m_w[m_cnt+4];
    end else begin
      w_i = $urandom; wp_i = $urandom;
    end
    if (ini) begin
      m_cv = IV; m_busy = 0; m_done = 0; m_cnt = 0;
    end else begin
      last = m_busy && vld && m_cnt == 63;
      m_done = last;
      if (m_busy && vld) m_cnt++;
      if (last) m_cv = m_tgt;
      if (st && (!m_busy || last)) begin
        expand(nxt_blk, m_w);
        m_tgt = compress(m_cv, nxt_blk);
        m_busy = 1; m_cnt = 0;
      end else if (last) m_busy = 0;
    end
    @(posedge clk); #1;
    check("R2 busy", {255'd0, busy_o}, {255'd0, m_busy});
    check("R6 done", {255'd0, done_o}, {255'd0, m_done});
    check("R4 R5 digest", digest_o, m_cv);
    init_i = 0; start_i = 0; w_valid_i = 0;
  endtask

  task automatic run_block(input logic [31:0] m[16], input bit stall);
    nxt_blk = m;
    cyc(0, 1, 1);
    while (m_busy) cyc(0, 0, stall ? (($urandom % 3) != 0) : 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [255:0] d1, d2;
    for (int i = 0; i < 16; i++) begin
      blk_abc[i] = 32'h0;
      blk_b[i]   = 32'h01234567 * (i + 3) ^ 32'hA5A5_0000;
    end
    blk_abc[0] = 32'h61626380; blk_abc[15] = 32'h00000018;
    m_cv = IV; m_busy = 0; m_done = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R1 reset digest", digest_o, IV);
    check("R1 reset busy", {255'd0, busy_o}, 256'd0);

    cyc(1, 0, 0);
    check("R1 init digest", digest_o, IV);
    run_block(blk_abc, 0);
    check("R11 known answer", digest_o, KAT);

    cyc(1, 0, 0);
    run_block(blk_abc, 1);
    check("R3 stalled known answer", digest_o, KAT);

    // R7 chaining with idle gap
    cyc(1, 0, 0);
    run_block(blk_abc, 0);
    repeat (3) cyc(0, 0, 0);
    run_block(blk_b, 1);
    check("R7 chained digest", digest_o, compress(KAT, blk_b));
    check("R5 second block", digest_o, m_cv);

    // R8 start on the final round
    cyc(1, 0, 0);
    nxt_blk = blk_abc;
    cyc(0, 1, 1);
    while (m_cnt != 63) cyc(0, 0, 1);
    nxt_blk = blk_b;
    cyc(0, 1, 1);
    check("R8 busy kept", {255'd0, busy_o}, 256'd1);
    check("R8 first digest", digest_o, KAT);
    while (m_busy) cyc(0, 0, 1);
    check("R8 second digest", digest_o, compress(KAT, blk_b));

    // R9 start while busy and valid while idle
    cyc(1, 0, 0);
    nxt_blk = blk_b;
    cyc(0, 1, 1);
    while (m_cnt != 10) cyc(0, 0, 1);
    nxt_blk = blk_abc;
    cyc(0, 1, 1);
    while (m_busy) cyc(0, 0, 1);
    check("R9 mid-block start ignored", digest_o, compress(IV, blk_b));
    d1 = digest_o;
    repeat (5) cyc(0, 0, 1);
    check("R9 idle valid ignored", digest_o, d1);
    check("R9 idle busy", {255'd0, busy_o}, 256'd0);

    // R10 init aborts a block
    nxt_blk = blk_abc;
    cyc(0, 1, 1);
    repeat (20) cyc(0, 0, 1);
    cyc(1, 0, 1);
    check("R10 abort digest", digest_o, IV);
    check("R10 abort busy", {255'd0, busy_o}, 256'd0);
    run_block(blk_abc, 1);
    d2 = digest_o;
    check("R10 clean rerun", d2, KAT);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule